// File: doc/BRIEF.md
# TDM Timeslot Switch Engine

This block is the serial core of a time-division-multiplexed port. It runs on the port's bit clock. It follows a frame sync and counts 8-bit timeslots, up to 1024 of them per frame. At the start of each slot it reads a control word for that slot from a host-written action table. The word decides what goes out on the serial output. It can be a byte captured from another slot in the previous frame (switching), or a byte taken from a transmit side-port (buffering). Otherwise the output is left undriven, with the output enable low.

Every received slot is written into a two-bank frame store, so any output slot can switch any input slot with a fixed one-frame delay. A slot can also be marked so that its received byte is offered on a receive side-port. Switched and buffered slots may be mixed freely within one frame. An entry that asks for both on one output slot is resolved in favour of switching and flagged.

Top module: `tdm_slot_engine`

## Requirements
- R1: A sync sampled high at a rising clock edge makes the bit period that starts at that edge bit 0 (MSB) of slot 0. Without sync, the slot count advances every 8 bits and returns to slot 0 after slot `last_slot`. `last_slot` may be as large as 1023.
- R2: Action entry fields are: bit 0 output enable, bit 1 buffered (1) or switched (0), bit 2 conflict marker, bit 3 receive-buffer enable, bits 13:4 source slot for switching.
- R3: `dout_oe` is low after reset until the first sync, and low for the whole of any slot whose entry has bit 0 clear.
- R4: A switched output slot sends, MSB first, the byte received in its source slot during the previous frame.
- R5: On a buffered slot, `tx_ready` is high in the bit period before the slot starts. If `tx_valid` is high at that edge, `tx_data` is sent. Otherwise 0xFF is sent and `tx_underrun` becomes set and stays set until reset.
- R6: An enabled entry with both bit 1 and bit 2 set is handled as a switched slot, and `conflict_err` becomes set and stays set until reset.
- R7: `din` is sampled on the falling clock edge. Bits are assembled MSB first. When a slot whose entry has bit 3 set completes, `rx_valid` rises with the byte in `rx_data` and the slot index in `rx_slot`, and stays high until `rx_ready` is seen. If a new byte replaces one that was not accepted, `rx_overrun` becomes set and stays set.
- R8: A sync arriving in the middle of a slot abandons that slot and restarts at bit 0 of slot 0 on the next period.
- R9: A write to the action table takes effect the next time the written slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; output launched on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync, sampled on rising edge |
| last_slot | input | 10 | Index of the final slot of a frame |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| act_we | input | 1 | Action table write strobe |
| act_addr | input | 10 | Action table slot index |
| act_wdata | input | 14 | Action table entry |
| tx_data | input | 8 | Transmit byte for buffered slots |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken at this edge |
| rx_data | output | 8 | Received byte from a receive-buffered slot |
| rx_slot | output | 10 | Slot index of `rx_data` |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Consumer accepts pending byte |
| conflict_err | output | 1 | Sticky: an entry asked for switch and buffer together |
| tx_underrun | output | 1 | Sticky: buffered slot started with no byte |
| rx_overrun | output | 1 | Sticky: pending receive byte overwritten |

## Verification
A wrong slot or bit count shows at the ports in the next bit period. The output enable and transmitted bit then follow the wrong entry, and the slot index on a received byte is wrong at the end of that slot. A frame-store bank mix-up only shows one frame later, as a switched slot carrying same-frame or two-frame-old data. So switched slots are checked across many consecutive frames, including a source slot that comes after its destination in the frame. Side-port mistakes show within the slot involved: a missing or misplaced `tx_ready` pulse, or a receive byte that is lost or overwritten. The sticky flags are compared every cycle, so a flag set at the wrong time, or never set, is seen at once.

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine #(
  parameter int SLOTS = 1024,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync,
  input  logic [$clog2(SLOTS)-1:0] last_slot,
  input  logic                     din,
  output logic                     dout,
  output logic                     dout_oe,
  input  logic                     act_we,
  input  logic [$clog2(SLOTS)-1:0] act_addr,
  input  logic [$clog2(SLOTS)+3:0] act_wdata,
  input  logic [W-1:0]             tx_data,
  input  logic                     tx_valid,
  output logic                     tx_ready,
  output logic [W-1:0]             rx_data,
  output logic [$clog2(SLOTS)-1:0] rx_slot,
  output logic                     rx_valid,
  input  logic                     rx_ready,
  output logic                     conflict_err,
  output logic                     tx_underrun,
  output logic                     rx_overrun
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(W);
  localparam int EW = SW + 4;

  logic [EW-1:0] act_mem [SLOTS];
  logic [W-1:0]  fstore  [2*SLOTS];

  logic          running, par, cur_rx, din_s;
  logic [BW-1:0] bit_idx;
  logic [SW-1:0] slot;
  logic [W-1:0]  tx_sh;
  logic [W-2:0]  rx_sh;

  wire           last_bit   = running && (bit_idx == BW'(W-1));
  wire           frm_start  = sync || (last_bit && (slot == last_slot));
  wire           slot_start = sync || last_bit;
  wire [SW-1:0]  nxt_slot   = frm_start ? '0 : slot + 1'b1;
  wire           nxt_par    = frm_start ? ~par : par;
  wire [EW-1:0]  ent        = act_mem[nxt_slot];
  wire           use_en     = ent[0];
  wire           clash      = ent[1] && ent[2];
  wire           buf_sel    = ent[1] && !ent[2];
  wire [W-1:0]   sw_byte    = fstore[{~nxt_par, ent[EW-1:4]}];
  wire [W-1:0]   rx_byte    = {rx_sh, din_s};
  wire [W-1:0]   ld_byte    = !use_en ? '1 : buf_sel ? (tx_valid ? tx_data : '1) : sw_byte;

  assign tx_ready = slot_start && use_en && buf_sel;
  assign dout     = tx_sh[W-1];

  always_ff @(posedge clk)
    if (act_we) act_mem[act_addr] <= act_wdata;

  always_ff @(posedge clk)
    if (last_bit) fstore[{par, slot}] <= rx_byte;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) din_s <= 1'b0;
    else        din_s <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;  par <= 1'b0;  cur_rx <= 1'b0;
      bit_idx <= '0;    slot <= '0;   tx_sh <= '1;   rx_sh <= '0;
      dout_oe <= 1'b0;  conflict_err <= 1'b0;  tx_underrun <= 1'b0;
    end else begin
      if (sync) running <= 1'b1;
      if (slot_start) begin
        bit_idx <= '0;
        slot    <= nxt_slot;
        par     <= nxt_par;
        dout_oe <= use_en;
        tx_sh   <= ld_byte;
        cur_rx  <= ent[3];
        if (use_en && clash)      conflict_err <= 1'b1;
        if (tx_ready && !tx_valid) tx_underrun <= 1'b1;
      end else if (running) begin
        bit_idx <= bit_idx + 1'b1;
        tx_sh   <= {tx_sh[W-2:0], 1'b1};
      end
      if (running) rx_sh <= rx_byte[W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;  rx_data <= '0;  rx_slot <= '0;  rx_overrun <= 1'b0;
    end else if (last_bit && cur_rx) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
      rx_slot  <= slot;
      if (rx_valid && !rx_ready) rx_overrun <= 1'b1;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assert_restart_on_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (slot == '0 && bit_idx == '0));
  assert_wrap_at_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sync && bit_idx == BW'(W-1) && slot == last_slot) |=> (slot == '0));
  assert_quiet_before_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !dout_oe);
  assert_ready_opens_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (bit_idx == '0 && dout_oe));
  assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun);
  assert_conflict_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |=> conflict_err);
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !(running && bit_idx == BW'(W-1)))
      |=> (rx_valid && $stable(rx_data) && $stable(rx_slot)));
endmodule

// File: tb/tb_tdm_slot_engine.sv
module tb_tdm_slot_engine;
  localparam int SLOTS = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sync, din, dout, dout_oe, act_we, tx_valid, tx_ready;
  logic rx_valid, rx_ready, conflict_err, tx_underrun, rx_overrun;
  logic [9:0] last_slot, act_addr, rx_slot;
  logic [13:0] act_wdata;
  logic [7:0] tx_data, rx_data;

  tdm_slot_engine dut (.*);

  int total = 0, bad = 0;
  string ptag = "";
  bit done = 0;

  bit m_run = 0, m_oe = 0, m_known = 0, m_rxen = 0, m_rv = 0;
  bit m_conf = 0, m_und = 0, m_ovr = 0;
  int m_b = 0, m_s = 0, m_fno = 0, m_acc = 0, m_byte = 255, m_rd = 0, m_rs = 0;
  logic [13:0] m_act [SLOTS];
  logic [7:0] got [int];
  int txq [$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s%s actual=%0h expected=%0h", req, ptag, act, exp);
    end
  endtask

  function automatic bit pred_ready(bit sy);
    int n;
    logic [13:0] e;
    if (!(sy || (m_run && m_b == 7))) return 0;
    n = sy ? 0 : (m_s == int'(last_slot)) ? 0 : (m_s + 1) % SLOTS;
    e = m_act[n];
    return e[0] && e[1] && !e[2];
  endfunction

  task automatic model_edge(bit sy, bit di, bit tv, bit rr, bit we, int wa, logic [13:0] wd);
    bit start = 0;
    logic [13:0] e;
    int key;
    if (m_run && m_b == 7 ) begin
      m_acc = ((m_acc << 1) | di) & 255;
      got[m_fno * 2048 + m_s] = m_acc[7:0];
      if (m_rxen) begin
        if (m_rv && !rr) m_ovr = 1;
        m_rv = 1; m_rd = m_acc; m_rs = m_s;
      end else if (rr) m_rv = 0;
    end else begin
      if (m_run) m_acc = ((m_acc << 1) | di) & 255;
      if (rr) m_rv = 0;
    end
    if (sy) begin
      m_run = 1; m_b = 0; m_s = 0; m_fno++; start = 1;
    end else if (m_run) begin
      if (m_b == 7) begin
        m_b = 0; start = 1;
        if (m_s == int'(last_slot)) begin m_s = 0; m_fno++; end
        else m_s = (m_s + 1) % SLOTS;
      end else m_b++;
    end
    if (start) begin
      e = m_act[m_s];
      m_oe = e[0]; m_rxen = e[3]; m_known = 1; m_byte = 255;
      if (e[0]) begin
        if (e[1] && e[2]) m_conf = 1;
        if (e[1] && !e[2]) begin
          if (tv) m_byte = txq.pop_front();
          else m_und = 1;
        end else begin
          key = (m_fno - 1) * 2048 + int'(e[13:4]);
          if (got.exists(key)) m_byte = got[key];
          else m_known = 0;
        end
      end
    end
    if (we) m_act[wa] = wd;
  endtask

  task automatic step(bit sy, bit di, bit tvq, bit rr,
                      bit we = 0, int wa = 0, logic [13:0] wd = '0);
    bit tv, er;
    tv = tvq && txq.size() > 0;
    sync = sy; din = di; tx_valid = tv; rx_ready = rr;
    tx_data = (txq.size() > 0) ? txq[0][7:0] : 8'h00;
    act_we = we; act_addr = wa[9:0]; act_wdata = wd;
    @(negedge clk); #2;
    er = pred_ready(sy);
    chk(tx_ready === er, "R5 tx_ready", tx_ready, er);
    @(posedge clk);
    model_edge(sy, di, tv, rr, we, wa, wd);
    #2;
    chk(dout_oe === m_oe, "R3 dout_oe", dout_oe, m_oe);
    if (m_oe && m_known)
      chk(dout === m_byte[7 - m_b], "R4 R2 dout", dout, m_byte[7 - m_b]);
    chk(rx_valid === m_rv, "R7 rx_valid", rx_valid, m_rv);
    if (m_rv) begin
      chk(rx_data === m_rd[7:0], "R7 rx_data", rx_data, m_rd);
      chk(rx_slot === m_rs[9:0], "R7 rx_slot", rx_slot, m_rs);
    end
    chk(conflict_err === m_conf, "R6 conflict_err", conflict_err, m_conf);
    chk(tx_underrun === m_und, "R5 tx_underrun", tx_underrun, m_und);
    chk(rx_overrun === m_ovr, "R7 rx_overrun", rx_overrun, m_ovr);
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic run(int n, int hold_lo = -1, int hold_hi = -1);
    for (int c = 0; c < n; c++) begin
      bit rr = !(c >= hold_lo && c < hold_hi);
      bit tv = rnd() | rnd();
      step(0, rnd(), tv, rr);
    end
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) m_act[i] = '0;
    rst_n = 0; sync = 0; din = 0; act_we = 0; act_addr = '0; act_wdata = '0;
    tx_valid = 0; tx_data = '0; rx_ready = 0; last_slot = 10'd7;
    repeat (3) @(posedge clk);
    #2;
    chk(dout_oe === 1'b0, "R3 reset oe", dout_oe, 0);
    chk(rx_valid === 1'b0, "R7 reset rx_valid", rx_valid, 0);
    chk({conflict_err, tx_underrun, rx_overrun} === 3'b000, "R5 R6 R7 reset flags",
        {conflict_err, tx_underrun, rx_overrun}, 0);
    rst_n = 1;
    ptag = " R3 init";
    for (int a = 0; a < SLOTS; a++) step(0, 0, 0, 1, 1, a, 14'h0);
    step(0, 0, 0, 1, 1, 0, 14'h051);
    step(0, 0, 0, 1, 1, 1, 14'h003);
    step(0, 0, 0, 1, 1, 2, 14'h008);
    step(0, 0, 0, 1, 1, 3, 14'h027);
    step(0, 0, 0, 1, 1, 4, 14'h041);
    step(0, 0, 0, 1, 1, 5, 14'h008);
    step(0, 0, 0, 1, 1, 6, 14'h00B);
    step(0, 0, 0, 1, 1, 7, 14'h071);
    for (int i = 0; i < 30; i++) txq.push_back((i * 37 + 5) & 255);
    ptag = " R2 R4 R1 mixed";
    step(1, rnd(), 1, 1);
    run(30 * 64, 320, 420);
    ptag = " R9 live write";
    step(0, rnd(), 1, 1, 1, 1, 14'h061);
    run(3 * 64);
    ptag = " R8 mid-slot sync";
    run(13);
    step(1, rnd(), 1, 1);
    chk(dout_oe === 1'b1, "R8 slot0 oe after resync", dout_oe, 1);
    run(3 * 64);
    ptag = " R1 long frame";
    step(0, rnd(), 1, 1, 1, 1023, 14'h3FF1);
    last_slot = 10'd1023;
    step(1, rnd(), 1, 1);
    run(2 * 8192 + 200);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule